// File: doc/BRIEF.md
# Tri-Level PWM Dead-Time Controller

This block turns a single three-state switching command into two gate enables for a half-bridge, one for the high-side switch and one for the low-side switch. The command reaches the block as a 2-bit code from an external window comparator. The code means low, high, or a middle "float" level. A high command selects the high-side switch. A low command selects the low-side switch. The middle level opens both switches.

Whenever either enable drops, both enables stay off for a programmable number of clock cycles before any enable may turn on again. This holds whether the next request is for the opposite switch or for the same one. The dead time is applied the same way for both switching directions. Its count is taken from the `dt_cycles` input in the clock edge where the enable drops. By default the field is sized to cover at least 220 ns at a 125 MHz clock.

A driver-enable input turns both switches off. A high-side undervoltage flag turns off only the high-side switch, and the low-side switch keeps following the command. Both outputs are registered, so an accepted request shows at the outputs one clock after it is sampled.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: With `pwm_code` = 2'b10, `drv_en` = 1 and `hs_uv` = 0 held, `hs_en` = 1 and `ls_en` = 0 once any dead interval has run out. `hs_en` only rises after a cycle in which those inputs held.
- R2: With `pwm_code` = 2'b00 and `drv_en` = 1 held, `ls_en` = 1 and `hs_en` = 0 once any dead interval has run out. `ls_en` only rises after a cycle in which those inputs held.
- R3: The codes 2'b01 (middle) and 2'b11 (reserved, treated as middle) turn both enables off in the cycle after they are sampled.
- R4: `drv_en` = 0 turns both enables off in the cycle after it is sampled, whatever `pwm_code` is.
- R5: `hs_uv` = 1 turns `hs_en` off in the cycle after it is sampled. While the flag is set, `ls_en` still follows a low command.
- R6: When an enable falls, both enables stay off for exactly max(D,1) cycles, where D is `dt_cycles` in the clock edge where the enable falls. Changes to `dt_cycles` during the interval have no effect. The requested side turns on in the next cycle.
- R7: If the command returns to the side that just dropped before the dead interval ends, that side turns on again only after the full interval.
- R8: `hs_en` and `ls_en` are never both 1 in the same cycle, for any input sequence.
- R9: While `rst_n` = 0 at a clock edge, both enables are 0 after that edge and the dead-time count is cleared. After release, a request turns its side on one cycle after it is sampled, even if reset arrived during a dead interval.
- R10: A `dt_cycles` value of 0 gives a dead interval of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_code | input | 2 | Command: 00 low, 01 middle, 10 high, 11 middle |
| drv_en | input | 1 | Driver enable; 0 forces both switches off |
| hs_uv | input | 1 | High-side supply undervoltage flag, active high |
| dt_cycles | input | DT_W (5 by default) | Dead time in clock cycles, sampled when an enable falls |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The assertions assume that `pwm_code`, `drv_en`, `hs_uv` and `dt_cycles` change only away from the rising edge. They also assume that reset is asserted for at least one edge before checking starts. The dead-interval check takes `dt_cycles` as it stands in the edge where an enable falls and assumes nothing about it at other times. The bench therefore changes `dt_cycles` during a dead interval on purpose. It drives every input on the falling clock edge. It holds reset for several edges at the start. It reaches every command code, including the reserved one, through the normal input pins only.

// File: rtl/hb_pkg.sv
// Shared types for the half-bridge dead-time controller.
// Assumes: the command code comes from an external comparator as 2 bits.
package hb_pkg;

    // Command codes as they arrive on the pin pair
    localparam logic [1:0] CODE_LO  = 2'b00;
    localparam logic [1:0] CODE_MID = 2'b01;
    localparam logic [1:0] CODE_HI  = 2'b10;

    // Qualified request after enable and supply gating
    typedef enum logic [1:0] {
        REQ_OFF = 2'd0,
        REQ_LO  = 2'd1,
        REQ_HI  = 2'd2
    } req_t;

    // Phase of the bridge sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LS   = 2'd1,
        PH_HS   = 2'd2,
        PH_DEAD = 2'd3
    } phase_t;

endpackage

// File: rtl/hb_cmd_decode.sv
// Command qualifier: maps the 2-bit command plus the enable and
// undervoltage flags onto a single side request.
// Assumes: inputs are already synchronous to clk; purely combinational.
module hb_cmd_decode
    import hb_pkg::*;
(
    input  logic [1:0] code_i,
    input  logic       drv_en_i,
    input  logic       hs_uv_i,
    output req_t       req_o
);

    // Decode command; middle and reserved codes, disable and UV map to off
    always_comb begin
        req_o = REQ_OFF;
        if (drv_en_i) begin
            unique case (code_i)
                CODE_LO:  req_o = REQ_LO;
                CODE_HI:  req_o = hs_uv_i ? REQ_OFF : REQ_HI;
                CODE_MID: req_o = REQ_OFF;
                default:  req_o = REQ_OFF;
            endcase
        end
    end

endmodule

// File: rtl/hb_dt_timer.sv
// Dead-time down-counter: loads the programmed count when an enable
// drops and flags expiry on its last dead cycle.
// Assumes: load is a single-cycle strobe from the sequencer; a load
// value of zero is clamped to one so every dead interval is nonempty.
module hb_dt_timer #(
    parameter int DT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DT_W-1:0] load_val_i,
    output logic            expired_o
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    logic [DT_W-1:0] cnt_q;

    // Count register: load on strobe, else step down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (load_val_i == '0) ? ONE : load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Last dead cycle reached (or counter idle)
    always_comb begin
        expired_o = (cnt_q <= ONE);
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R10
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q != '0));

endmodule

// File: rtl/hb_phase_fsm.sv
// Bridge sequencer: holds one side on while it stays requested, passes
// through a dead phase after every drop, then serves the current request.
// Assumes: expired_i comes from hb_dt_timer loaded by load_o.
module hb_phase_fsm
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  req_t req_i,
    input  logic expired_i,
    output logic load_o,
    output logic hs_en_o,
    output logic ls_en_o
);

    phase_t ph_q, ph_d;

    // Next phase and timer load strobe
    always_comb begin
        ph_d   = ph_q;
        load_o = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req_i == REQ_HI)      ph_d = PH_HS;
                else if (req_i == REQ_LO) ph_d = PH_LS;
            end
            PH_HS: begin
                if (req_i != REQ_HI) begin
                    ph_d   = PH_DEAD;
                    load_o = 1'b1;
                end
            end
            PH_LS: begin
                if (req_i != REQ_LO) begin
                    ph_d   = PH_DEAD;
                    load_o = 1'b1;
                end
            end
            PH_DEAD: begin
                if (expired_i) begin
                    if (req_i == REQ_HI)      ph_d = PH_HS;
                    else if (req_i == REQ_LO) ph_d = PH_LS;
                    else                      ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase and registered gate enables, both cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            hs_en_o <= 1'b0;
            ls_en_o <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            hs_en_o <= (ph_d == PH_HS);
            ls_en_o <= (ph_d == PH_LS);
        end
    end

    // R6
    dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DEAD && !expired_i) |=> (ph_q == PH_DEAD));

    // R7
    drop_to_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_en_o) || $fell(ls_en_o)) |-> (ph_q == PH_DEAD));

endmodule

// File: rtl/hb_deadtime_ctrl.sv
// Tri-level PWM dead-time controller, top level. Qualifies the 2-bit
// command, sequences the bridge and times the dead interval.
// Assumes: all inputs synchronous to clk; dt_cycles is read only in the
// edge where an enable falls.
module hb_deadtime_ctrl
    import hb_pkg::*;
#(
    parameter  int CLK_PERIOD_PS = 8000,
    parameter  int DT_MAX_PS     = 220000,
    localparam int DT_MIN_CYC    = (DT_MAX_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS,
    localparam int DT_W          = $clog2(DT_MIN_CYC + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      pwm_code,
    input  logic            drv_en,
    input  logic            hs_uv,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            hs_en,
    output logic            ls_en
);

    req_t req;
    logic dt_load;
    logic dt_expired;

    hb_cmd_decode u_dec (
        .code_i   (pwm_code),
        .drv_en_i (drv_en),
        .hs_uv_i  (hs_uv),
        .req_o    (req)
    );

    hb_dt_timer #(.DT_W(DT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (dt_load),
        .load_val_i (dt_cycles),
        .expired_o  (dt_expired)
    );

    hb_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .expired_i (dt_expired),
        .load_o    (dt_load),
        .hs_en_o   (hs_en),
        .ls_en_o   (ls_en)
    );

    // ---------------- checker state for the dead-gap property ----------------
    localparam int GW = DT_W + 1;
    logic [GW-1:0]   gap_q;
    logic [DT_W-1:0] dt_snap_q;
    logic            armed_q;
    logic [GW-1:0]   dt_eff;

    // Track off cycles since the last drop and the count in force then
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            dt_snap_q <= '0;
            armed_q   <= 1'b0;
        end else if (dt_load) begin
            gap_q     <= GW'(1);
            dt_snap_q <= dt_cycles;
            armed_q   <= 1'b1;
        end else if (!hs_en && !ls_en && gap_q != '1) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // Effective interval with zero clamped to one
    always_comb begin
        dt_eff = (dt_snap_q == '0) ? GW'(1) : {1'b0, dt_snap_q};
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!hs_en && !ls_en));

    // R4
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (!hs_en && !ls_en));

    // R3
    mid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_code == 2'b01 || pwm_code == 2'b11) |=> (!hs_en && !ls_en));

    // R5
    uv_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_uv |=> !hs_en);

    // R1
    hs_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(pwm_code == 2'b10 && drv_en && !hs_uv));

    // R2
    ls_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(pwm_code == 2'b00 && drv_en));

    // R6
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_en) || $rose(ls_en)) |-> (!armed_q || $past(gap_q) >= dt_eff));

endmodule

// File: tb/sim_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_hb_deadtime_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_code = 2'b01;
    logic       drv_en = 1'b0;
    logic       hs_uv = 1'b0;
    logic [4:0] dt_cycles = 5'd3;
    logic       hs_en;
    logic       ls_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int    mode;   // 0 none, 1 exact, 2 non-overlap only
        bit    hs;
        bit    ls;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    hb_deadtime_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_code  (pwm_code),
        .drv_en    (drv_en),
        .hs_uv     (hs_uv),
        .dt_cycles (dt_cycles),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

    // Driver: apply one cycle of inputs and queue the outcome after the next edge
    task automatic step(input bit r, input logic [1:0] p, input bit e, input bit u,
                        input logic [4:0] d, input int mode, input bit xh,
                        input bit xl, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r; pwm_code = p; drv_en = e; hs_uv = u; dt_cycles = d;
        it.mode = mode; it.hs = xh; it.ls = xl; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare outputs shortly after each rising edge
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (q.size() > 0) begin
            it = q.pop_front();
            if (it.mode == 1) begin
                n_run++;
                if (hs_en !== it.hs || ls_en !== it.ls) begin
                    n_fail++;
                    $display("FAIL %s: actual hs=%b ls=%b expected hs=%b ls=%b",
                             it.tag, hs_en, ls_en, it.hs, it.ls);
                end
            end else if (it.mode == 2) begin
                n_run++;
                if (hs_en === 1'b1 && ls_en === 1'b1) begin
                    n_fail++;
                    $display("FAIL %s: actual hs=1 ls=1 expected not both", it.tag);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        // R9: reset state
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, 0, 3, 1, 0, 0, "R9 reset");
        // R2, R9: first request after release, one cycle latency
        step(1, 2'b00, 1, 0, 3, 1, 0, 1, "R9 R2 low after release");
        for (int i = 0; i < 2; i++) step(1, 2'b00, 1, 0, 3, 1, 0, 1, "R2 low held");
        // R6, R1: low to high with three dead cycles
        for (int i = 0; i < 3; i++) step(1, 2'b10, 1, 0, 3, 1, 0, 0, "R6 dead low->high");
        step(1, 2'b10, 1, 0, 3, 1, 1, 0, "R1 R6 high after dead");
        step(1, 2'b10, 1, 0, 3, 1, 1, 0, "R1 high held");
        // R3, R7: middle then back to high waits the full interval
        step(1, 2'b01, 1, 0, 3, 1, 0, 0, "R3 middle off");
        for (int i = 0; i < 2; i++) step(1, 2'b10, 1, 0, 3, 1, 0, 0, "R7 same side waits");
        step(1, 2'b10, 1, 0, 3, 1, 1, 0, "R7 same side after dead");
        // R3: reserved code, then to low
        step(1, 2'b11, 1, 0, 3, 1, 0, 0, "R3 code 11 off");
        for (int i = 0; i < 2; i++) step(1, 2'b00, 1, 0, 3, 1, 0, 0, "R6 dead high->low");
        step(1, 2'b00, 1, 0, 3, 1, 0, 1, "R6 R2 low after dead");
        // R4: disable forces off regardless of command
        for (int i = 0; i < 6; i++) step(1, 2'b00, 0, 0, 3, 1, 0, 0, "R4 disabled");
        step(1, 2'b00, 1, 0, 3, 1, 0, 1, "R4 re-enabled low");
        // R1: to high again
        for (int i = 0; i < 3; i++) step(1, 2'b10, 1, 0, 3, 1, 0, 0, "R6 dead low->high 2");
        step(1, 2'b10, 1, 0, 3, 1, 1, 0, "R1 high");
        // R5: undervoltage removes high side, low side still served
        for (int i = 0; i < 6; i++) step(1, 2'b10, 1, 1, 3, 1, 0, 0, "R5 uv high off");
        for (int i = 0; i < 2; i++) step(1, 2'b00, 1, 1, 3, 1, 0, 1, "R5 uv low follows");
        // R10: zero dead time gives one cycle
        step(1, 2'b10, 1, 0, 0, 1, 0, 0, "R10 one dead cycle");
        step(1, 2'b10, 1, 0, 0, 1, 1, 0, "R10 high after one cycle");
        // R6: long interval, count taken at the drop, later changes ignored
        step(1, 2'b00, 1, 0, 28, 1, 0, 0, "R6 drop dt=28");
        for (int i = 0; i < 27; i++) step(1, 2'b00, 1, 0, 2, 1, 0, 0, "R6 long dead");
        step(1, 2'b00, 1, 0, 2, 1, 0, 1, "R6 low after 28");
        // R9: reset in the middle of a dead interval clears the count
        step(1, 2'b10, 1, 0, 20, 1, 0, 0, "R6 drop before reset");
        step(0, 2'b10, 1, 0, 20, 1, 0, 0, "R9 reset mid dead");
        step(1, 2'b00, 1, 0, 20, 1, 0, 1, "R9 low right after reset");
        // R8: pseudo-random stress for non-overlap
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1, lfsr[1:0], lfsr[5] | lfsr[6], lfsr[7] & lfsr[3],
                 {2'b00, lfsr[4:2]}, 2, 0, 0, "R8 no overlap");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule